// File: doc/BRIEF.md
# Letterboxed Framebuffer Scan Controller

This block generates the raster timing for a display that scans one of two 64 KB framebuffers held in a 128 KB video memory. A prescaler divides the system clock into a dot tick. A horizontal counter and a vertical counter advance on that tick. The current position of both counters is available on two read ports.

A 16-bit graphics-mode word is written over an I/O port. It turns the display on or off, selects 4 or 8 bits per pixel and picks a palette. It also sets how many lines to blank at the top and bottom of the frame (letterboxing), and chooses the front buffer. From the counters and the applied mode, the block drives these outputs:
- horizontal and vertical blank flags;
- an active-display flag;
- the linear video-memory byte address of the current pixel, with a nibble select for 4 bpp.

The block also reports which buffer the CPU may use. A newly written mode takes effect only on the edge where the raster returns to its origin, so a buffer flip never tears a frame.

Top module: `fb_scan_ctrl`

## Requirements
- R1: `hpos_o` counts dot positions 0 to H_TOTAL-1 (default 415) and then returns to 0.
- R2: `vpos_o` steps by one only on the dot where the horizontal count wraps. It runs 0 to V_TOTAL-1 (default 261) and then returns to 0.
- R3: The counters advance exactly once every DOT_DIV (default 4) clock cycles.
- R4: The mode word is decoded as follows. Bit 15 is the display enable; when it is 0, `active_o` stays low. Bit 14 is the depth (0 means 4 bpp, 1 means 8 bpp) and is shown on `depth8_o`. Bits 12:11 are the palette select and are shown on `pal_o`.
- R5: Bits 10:6 give T, the number of letterbox lines at the top. Bits 5:1 give B, the number at the bottom. A line v is displayed only when v >= T and v + B < V_ACTIVE (default 240). `vblank_o` is high on every other line. `hblank_o` is high for h >= H_ACTIVE (default 320). `active_o` is high only when the display is enabled and neither blank flag is set.
- R6: `pix_addr_o` is {front bit, 16-bit offset}. The pixel index counts displayed pixels from 0 at the first displayed pixel of each frame. In 8 bpp the offset equals the index and `pix_nib_o` is 0. In 4 bpp the offset is the index shifted right by one and `pix_nib_o` is bit 0 of the index.
- R7: A mode write takes effect only on the dot tick where the raster wraps from (H_TOTAL-1, V_TOTAL-1) to (0, 0).
- R8: Bit 0 selects the front buffer (0 for the lower 64 KB, 1 for the upper). `cpu_buf_o` is always the other buffer.
- R9: Bit 13 is reserved and has no effect on any output.
- R10: When T + B >= V_ACTIVE, no line of the frame is displayed.
- R11: After reset, both counters are 0, the display is disabled, the front buffer is the lower one, `cpu_buf_o` is 1 and `pix_addr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_wr_i | input | 1 | Mode port write strobe |
| mode_wdata_i | input | 16 | Mode word |
| hpos_o | output | 16 | Horizontal position read port |
| vpos_o | output | 16 | Vertical position read port |
| dot_tick_o | output | 1 | Dot clock enable pulse |
| hblank_o | output | 1 | Horizontal blank |
| vblank_o | output | 1 | Vertical blank, including letterbox lines |
| active_o | output | 1 | Pixel is displayed |
| depth8_o | output | 1 | Applied depth, 1 for 8 bpp |
| pal_o | output | 2 | Applied palette select |
| pix_addr_o | output | OFF_W+1 | Video-memory byte address of current pixel |
| pix_nib_o | output | 1 | Nibble select in 4 bpp |
| cpu_buf_o | output | 1 | Buffer the CPU may access |

## Verification
The hardest behaviour to reach from the ports is the deferral of a mode write. The write has to land mid-frame, the old mode has to be observed to persist over later displayed positions of the same frame, and the new mode has to appear only after the wrap. The bench waits on the position read ports to reach chosen raster coordinates, writes the mode there, and checks the outputs at later coordinates of the same frame and of the following frame. Each letterbox and address corner is reached the same way: the bench steers to the exact (h, v) where a boundary falls and compares the outputs against values it computes from the coordinates.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  typedef struct packed {
    logic       en;
    logic       depth8;
    logic [1:0] pal;
    logic [4:0] top;
    logic [4:0] bot;
    logic       front;
  } mode_t;

  // bit 13 reserved
  function automatic mode_t decode_mode(input logic [15:0] w);
    mode_t m;
    m.en     = w[15];
    m.depth8 = w[14];
    m.pal    = w[12:11];
    m.top    = w[10:6];
    m.bot    = w[5:1];
    m.front  = w[0];
    return m;
  endfunction
endpackage

// File: rtl/fbs_dot_div.sv
module fbs_dot_div #(
  parameter int DOT_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (DOT_DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DOT_DIV);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                         cnt_q <= '0;
        else if (cnt_q == CW'(DOT_DIV - 1))  cnt_q <= '0;
        else                                 cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == CW'(DOT_DIV - 1));

      assert_tick_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/fbs_raster.sv
module fbs_raster #(
  parameter int H_TOTAL = 416,
  parameter int V_TOTAL = 262,
  localparam int H_W = $clog2(H_TOTAL),
  localparam int V_W = $clog2(V_TOTAL)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  output logic [H_W-1:0] hcnt_o,
  output logic [V_W-1:0] vcnt_o,
  output logic           frame_end_o
);
  logic [H_W-1:0] hcnt_q;
  logic [V_W-1:0] vcnt_q;
  logic h_last, v_last;

  assign h_last = (hcnt_q == H_W'(H_TOTAL - 1));
  assign v_last = (vcnt_q == V_W'(V_TOTAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
      vcnt_q <= '0;
    end else if (tick_i) begin
      if (h_last) begin
        hcnt_q <= '0;
        vcnt_q <= v_last ? '0 : vcnt_q + 1'b1;
      end else begin
        hcnt_q <= hcnt_q + 1'b1;
      end
    end
  end

  assign hcnt_o      = hcnt_q;
  assign vcnt_o      = vcnt_q;
  assign frame_end_o = tick_i && h_last && v_last;

  assert_h_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hcnt_q < H_W'(H_TOTAL));
  assert_v_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vcnt_q != $past(vcnt_q)) |-> ($past(h_last) && $past(tick_i)));
  assert_v_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vcnt_q < V_W'(V_TOTAL));
endmodule

// File: rtl/fbs_mode.sv
module fbs_mode
  import fbs_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [15:0] wdata_i,
  input  logic        frame_end_i,
  output mode_t       mode_o
);
  logic [15:0] pend_q;
  mode_t       cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      cur_q  <= '0;
    end else begin
      if (wr_i)        pend_q <= wdata_i;
      if (frame_end_i) cur_q  <= decode_mode(pend_q);
    end
  end

  assign mode_o = cur_q;

  assert_mode_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_i |=> $stable(cur_q));
endmodule

// File: rtl/fbs_addr.sv
module fbs_addr #(
  parameter int OFF_W = 16,
  localparam int IDX_W = OFF_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             frame_end_i,
  input  logic             active_i,
  input  logic             depth8_i,
  output logic [OFF_W-1:0] off_o,
  output logic             nib_o
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     idx_q <= '0;
    else if (tick_i && frame_end_i)  idx_q <= '0;
    else if (tick_i && active_i)     idx_q <= idx_q + 1'b1;
  end

  assign off_o = depth8_i ? idx_q[OFF_W-1:0] : idx_q[IDX_W-1:1];
  assign nib_o = depth8_i ? 1'b0 : idx_q[0];

  assert_idx_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && frame_end_i) |=> (idx_q == '0));
  assert_idx_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(idx_q));
endmodule

// File: rtl/fb_scan_ctrl.sv
module fb_scan_ctrl
  import fbs_pkg::*;
#(
  parameter int DOT_DIV  = 4,
  parameter int H_TOTAL  = 416,
  parameter int H_ACTIVE = 320,
  parameter int V_TOTAL  = 262,
  parameter int V_ACTIVE = 240,
  parameter int OFF_W    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_wr_i,
  input  logic [15:0]      mode_wdata_i,
  output logic [15:0]      hpos_o,
  output logic [15:0]      vpos_o,
  output logic             dot_tick_o,
  output logic             hblank_o,
  output logic             vblank_o,
  output logic             active_o,
  output logic             depth8_o,
  output logic [1:0]       pal_o,
  output logic [OFF_W:0]   pix_addr_o,
  output logic             pix_nib_o,
  output logic             cpu_buf_o
);
  localparam int H_W = $clog2(H_TOTAL);
  localparam int V_W = $clog2(V_TOTAL);
  localparam int C_W = V_W + 1;

  logic           tick, frame_end;
  logic [H_W-1:0] hcnt;
  logic [V_W-1:0] vcnt;
  mode_t          mode;
  logic [OFF_W-1:0] off;
  logic           line_vis;

  fbs_dot_div #(.DOT_DIV(DOT_DIV)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick));

  fbs_raster #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL)) u_raster (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .hcnt_o(hcnt), .vcnt_o(vcnt), .frame_end_o(frame_end));

  fbs_mode u_mode (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(mode_wr_i), .wdata_i(mode_wdata_i),
    .frame_end_i(frame_end), .mode_o(mode));

  // line shown when past the top letterbox and clear of the bottom one
  assign line_vis = ({1'b0, vcnt} >= C_W'(mode.top)) &&
                    (({1'b0, vcnt} + C_W'(mode.bot)) < C_W'(V_ACTIVE));

  assign hblank_o = (hcnt >= H_W'(H_ACTIVE));
  assign vblank_o = !line_vis;
  assign active_o = mode.en && !hblank_o && line_vis;

  fbs_addr #(.OFF_W(OFF_W)) u_addr (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .frame_end_i(frame_end),
    .active_i(active_o), .depth8_i(mode.depth8), .off_o(off), .nib_o(pix_nib_o));

  assign hpos_o     = 16'(hcnt);
  assign vpos_o     = 16'(vcnt);
  assign dot_tick_o = tick;
  assign depth8_o   = mode.depth8;
  assign pal_o      = mode.pal;
  assign pix_addr_o = {mode.front, off};
  assign cpu_buf_o  = !mode.front;

  assert_cpu_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_buf_o != pix_addr_o[OFF_W]);
  assert_no_active_disabled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !$past(active_o) && !$past(frame_end)) |-> $past(mode.en));
endmodule

// File: tb/fb_scan_ctrl_tb.sv
module fb_scan_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DD = 2, HT = 20, HA = 8, VT = 40, VA = 30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_wr = 1'b0;
  logic [15:0] mode_wd = '0;
  logic [15:0] hpos, vpos;
  logic dot_tick, hblank, vblank, active, depth8, nib, cpu_buf;
  logic [1:0] pal;
  logic [16:0] addr;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fb_scan_ctrl #(.DOT_DIV(DD), .H_TOTAL(HT), .H_ACTIVE(HA), .V_TOTAL(VT),
                 .V_ACTIVE(VA), .OFF_W(16)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_wr_i(mode_wr), .mode_wdata_i(mode_wd),
    .hpos_o(hpos), .vpos_o(vpos), .dot_tick_o(dot_tick), .hblank_o(hblank),
    .vblank_o(vblank), .active_o(active), .depth8_o(depth8), .pal_o(pal),
    .pix_addr_o(addr), .pix_nib_o(nib), .cpu_buf_o(cpu_buf));

  function automatic logic [15:0] mk(bit en, bit d8, bit rsv, int p, int t, int b, bit f);
    return {en, d8, rsv, 2'(p), 5'(t), 5'(b), f};
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic goto(int h, int v);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(hpos == 16'(h) && vpos == 16'(v)) && n < 20000);
  endtask

  task automatic next_frame();
    goto(0, VT - 1);
    goto(0, 0);
  endtask

  task automatic wr_mode(logic [15:0] w);
    @(negedge clk);
    mode_wr = 1'b1;
    mode_wd = w;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 hpos", hpos, 0);
    chk("R11 vpos", vpos, 0);
    chk("R11 active", active, 0);
    chk("R11 cpu_buf", cpu_buf, 1);
    chk("R11 addr", addr, 0);
  endtask

  task automatic t_raster();
    int n = 0;
    goto(HT - 1, 3);
    do begin @(negedge clk); n++; end while (hpos != 0 && n < 100);
    chk("R3 dot period", n, DD);
    chk("R1 h wrap", hpos, 0);
    chk("R2 v step", vpos, 4);
    goto(HT - 2, 5);
    n = 0;
    do begin @(negedge clk); n++; end while (hpos == 16'(HT - 2) && n < 100);
    chk("R2 v held mid-line", vpos, 5);
    goto(HT - 1, VT - 1);
    do @(negedge clk); while (hpos != 0);
    chk("R2 v wrap", vpos, 0);
  endtask

  task automatic t_defer();
    goto(3, 2);
    wr_mode(mk(1, 1, 0, 0, 0, 0, 1));
    goto(1, 5);
    chk("R7 old mode active", active, 0);
    chk("R7 old cpu_buf", cpu_buf, 1);
    next_frame();
    goto(1, 5);
    chk("R7 new mode active", active, 1);
    chk("R8 cpu_buf other", cpu_buf, 0);
    chk("R8 front in addr", addr[16], 1);
  endtask

  task automatic t_letterbox();
    wr_mode(mk(1, 1, 0, 2, 3, 4, 1));
    next_frame();
    chk("R4 pal", pal, 2);
    chk("R4 depth8", depth8, 1);
    goto(0, 2);
    chk("R5 top box active", active, 0);
    chk("R5 top box vblank", vblank, 1);
    goto(0, 3);
    chk("R5 first line", active, 1);
    chk("R6 first pixel addr", addr, 17'h10000);
    goto(5, 5);
    chk("R6 8bpp addr", addr, 17'h10000 | ((5 - 3) * HA + 5));
    chk("R6 8bpp nib", nib, 0);
    goto(HA, 5);
    chk("R5 hblank", hblank, 1);
    chk("R5 hblank active", active, 0);
    goto(0, VA - 4 - 1);
    chk("R5 last line", active, 1);
    goto(0, VA - 4);
    chk("R5 bottom box", active, 0);
    chk("R5 bottom vblank", vblank, 1);
  endtask

  task automatic t_addr4();
    wr_mode(mk(1, 0, 0, 1, 0, 0, 0));
    next_frame();
    goto(3, 2);
    chk("R6 4bpp addr", addr, (2 * HA + 3) >> 1);
    chk("R6 4bpp nib", nib, 1);
    chk("R4 depth4", depth8, 0);
    chk("R8 lower front", cpu_buf, 1);
  endtask

  task automatic t_reserved();
    wr_mode(mk(1, 0, 1, 1, 0, 0, 0));
    next_frame();
    goto(3, 2);
    chk("R9 addr", addr, (2 * HA + 3) >> 1);
    chk("R9 nib", nib, 1);
    chk("R9 active", active, 1);
    chk("R9 pal", pal, 1);
    chk("R9 depth", depth8, 0);
  endtask

  task automatic t_disable();
    wr_mode(mk(0, 1, 0, 0, 0, 0, 0));
    next_frame();
    goto(1, 1);
    chk("R4 disabled active", active, 0);
    chk("R4 disabled vblank", vblank, 0);
  endtask

  task automatic t_overlap();
    wr_mode(mk(1, 1, 0, 0, 20, 15, 0));
    next_frame();
    goto(1, 10);
    chk("R10 line 10", active, 0);
    goto(1, 20);
    chk("R10 line 20", active, 0);
    chk("R10 vblank", vblank, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_raster();
    t_defer();
    t_letterbox();
    t_addr4();
    t_reserved();
    t_disable();
    t_overlap();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule